// File: doc/BRIEF.md
# Watchdog Violation Status Register

This block keeps a sticky record of why a windowed watchdog fired. Three single-cycle event pulses arrive from the watchdog core: the counter ran past the end of its window, a key was written before the window opened, or a wrong key or key sequence was written. Each event sets its own flag on the next clock edge. Timing violations also set a window-violation summary flag. The flags stay set until software clears them or a power-on reset occurs. A soft reset does not touch them, so the cause is still visible after the system restarts.

Software reads one 32-bit status word. It clears flags by writing ones, and such writes are accepted only when they are privileged. Writing 1 to the summary bit clears all flags at once. When the watchdog is configured for interrupt mode, a non-maskable interrupt request follows the summary flag. That request holds until software clears the flag.

Top module: `wdv_status_reg`

## Requirements
- R1: Power-on reset (por_n low) clears every flag: rd_data reads 0x00000000 and nmi_req is 0.
- R2: Bits 31..6 and bit 0 of rd_data always read 0. Writing ones to those bits changes no flag.
- R3: An evt_end_expiry pulse sets bit 4, its mirror bit 1, and summary bit 5, all visible after the next rising clock edge.
- R4: An evt_early_key pulse sets bit 3 and summary bit 5 after the next rising clock edge.
- R5: An evt_bad_key pulse sets bit 2 after the next rising clock edge and leaves bit 5 as it was.
- R6: Flags are sticky. They hold with no event present, and asserting soft_rst leaves every flag and nmi_req unchanged.
- R7: In a privileged write, a 0 in a status bit leaves that flag unchanged. A 1 in bit 3 or bit 2 clears only that flag. A 1 in bit 4 or bit 1 clears the shared expiry flag, so both bits read 0 and bit 5 stays set.
- R8: A privileged write with bit 5 set clears bits 5, 4, 3, 2 and 1 together.
- R9: A write with wr_priv low is ignored. A write presented while soft_rst is high is also ignored.
- R10: When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R11: nmi_req is 1 exactly when bit 5 is set and irq_mode is 1. It falls in the cycle after bit 5 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, active high; flags are kept |
| evt_end_expiry | input | 1 | Pulse: counter expired past window end |
| evt_early_key | input | 1 | Pulse: key written before window opened |
| evt_bad_key | input | 1 | Pulse: wrong key value or sequence |
| wr_en | input | 1 | Write strobe for the status word |
| wr_priv | input | 1 | Write is made in privileged mode |
| wr_data | input | 32 | Write data, write-1-to-clear |
| irq_mode | input | 1 | 1 = watchdog signals by interrupt instead of reset |
| rd_data | output | 32 | Status word |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
A wrong flag state appears directly in rd_data one edge after the event or write that caused it. A stuck or mis-set summary flag also appears on nmi_req in that same cycle when irq_mode is high. A broken mirror between bits 4 and 1 shows as a mismatched pair on the next read. A clear that leaks past the privilege or soft-reset qualifier drops a flag one cycle after the write. A lost set-over-clear priority shows as a zero where the same-cycle event should have left a one.

// File: rtl/wdv_pkg.sv
package wdv_pkg;
  localparam int REG_W = 32;
  localparam int NFLAG = 4;

  // Index of each stored flag inside the flag vector
  localparam int FL_KEY   = 0;
  localparam int FL_EARLY = 1;
  localparam int FL_END   = 2;
  localparam int FL_WIN   = 3;

  // Bit positions in the status word, fixed by software view
  localparam int POS_MIRROR = 1;
  localparam int POS_KEY    = 2;
  localparam int POS_EARLY  = 3;
  localparam int POS_END    = 4;
  localparam int POS_WIN    = 5;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << POS_WIN) | (REG_W'(1) << POS_END) | (REG_W'(1) << POS_EARLY) |
    (REG_W'(1) << POS_KEY) | (REG_W'(1) << POS_MIRROR);

  // Events that set each flag
  function automatic logic [NFLAG-1:0] set_request(input logic ev_end,
                                                   input logic ev_early,
                                                   input logic ev_key);
    logic [NFLAG-1:0] s;
    s          = '0;
    s[FL_WIN]  = ev_end | ev_early;
    s[FL_END]  = ev_end;
    s[FL_EARLY]= ev_early;
    s[FL_KEY]  = ev_key;
    return s;
  endfunction

  // Ones written that request a clear of each flag
  function automatic logic [NFLAG-1:0] clr_request(input logic [REG_W-1:0] d);
    logic [NFLAG-1:0] c;
    c           = '0;
    c[FL_WIN]   = d[POS_WIN];
    c[FL_END]   = d[POS_END] | d[POS_MIRROR] | d[POS_WIN];
    c[FL_EARLY] = d[POS_EARLY] | d[POS_WIN];
    c[FL_KEY]   = d[POS_KEY] | d[POS_WIN];
    return c;
  endfunction

  // Place stored flags into the status word
  function automatic logic [REG_W-1:0] pack_status(input logic [NFLAG-1:0] f);
    logic [REG_W-1:0] r;
    r             = '0;
    r[POS_WIN]    = f[FL_WIN];
    r[POS_END]    = f[FL_END];
    r[POS_MIRROR] = f[FL_END];
    r[POS_EARLY]  = f[FL_EARLY];
    r[POS_KEY]    = f[FL_KEY];
    return r;
  endfunction
endpackage

// File: rtl/wdv_flag.sv
module wdv_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Set has priority over clear; only power-on reset initialises
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/wdv_clr_decode.sv
module wdv_clr_decode
  import wdv_pkg::*;
(
  input  logic             wr_en,
  input  logic             wr_priv,
  input  logic             soft_rst,
  input  logic [REG_W-1:0] wr_data,
  output logic             accept_o,
  output logic [NFLAG-1:0] clr_o
);
  assign accept_o = wr_en & wr_priv & ~soft_rst;
  assign clr_o    = accept_o ? clr_request(wr_data) : '0;
endmodule

// File: rtl/wdv_status_reg.sv
module wdv_status_reg
  import wdv_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             evt_end_expiry,
  input  logic             evt_early_key,
  input  logic             evt_bad_key,
  input  logic             wr_en,
  input  logic             wr_priv,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_mode,
  output logic [REG_W-1:0] rd_data,
  output logic             nmi_req
);
  logic             wr_accept;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flag_q;

  assign set_vec = set_request(evt_end_expiry, evt_early_key, evt_bad_key);

  wdv_clr_decode i_dec (
    .wr_en    (wr_en),
    .wr_priv  (wr_priv),
    .soft_rst (soft_rst),
    .wr_data  (wr_data),
    .accept_o (wr_accept),
    .clr_o    (clr_vec)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    wdv_flag i_flag (
      .clk   (clk),
      .por_n (por_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (flag_q[g])
    );
  end

  assign rd_data = pack_status(flag_q);
  assign nmi_req = flag_q[FL_WIN] & irq_mode;
endmodule

// File: rtl/wdv_status_chk.sv
module wdv_status_chk
  import wdv_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             soft_rst,
  input logic             evt_end_expiry,
  input logic             evt_early_key,
  input logic             evt_bad_key,
  input logic             wr_en,
  input logic             wr_priv,
  input logic [REG_W-1:0] wr_data,
  input logic             irq_mode,
  input logic [REG_W-1:0] rd_data,
  input logic             nmi_req
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data & ~LIVE_MASK) == '0);

  // R3
  end_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt_end_expiry |=> (rd_data[POS_END] && rd_data[POS_MIRROR] && rd_data[POS_WIN]));

  // R4
  early_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt_early_key |=> (rd_data[POS_EARLY] && rd_data[POS_WIN]));

  // R5
  key_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt_bad_key |=> rd_data[POS_KEY]);

  // R4
  summary_cover_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[POS_END] || rd_data[POS_EARLY]) |-> rd_data[POS_WIN]);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && wr_priv && !soft_rst) |=> (($past(rd_data) & ~rd_data) == '0));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_priv && !soft_rst && wr_data[POS_WIN] &&
     !evt_end_expiry && !evt_early_key && !evt_bad_key) |=> (rd_data == '0));

  // R11
  nmi_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    (irq_mode && rd_data[POS_WIN]) |-> nmi_req);

  // R11
  nmi_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!irq_mode || !rd_data[POS_WIN]) |-> !nmi_req);
endmodule

bind wdv_status_reg wdv_status_chk i_chk (
  .clk            (clk),
  .por_n          (por_n),
  .soft_rst       (soft_rst),
  .evt_end_expiry (evt_end_expiry),
  .evt_early_key  (evt_early_key),
  .evt_bad_key    (evt_bad_key),
  .wr_en          (wr_en),
  .wr_priv        (wr_priv),
  .wr_data        (wr_data),
  .irq_mode       (irq_mode),
  .rd_data        (rd_data),
  .nmi_req        (nmi_req)
);

// File: tb/test_wdv_status_reg.sv
`timescale 1ns/1ps
module test_wdv_status_reg;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        evt_end_expiry = 1'b0;
  logic        evt_early_key = 1'b0;
  logic        evt_bad_key = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_priv = 1'b0;
  logic [31:0] wr_data = '0;
  logic        irq_mode = 1'b1;
  logic [31:0] rd_data;
  logic        nmi_req;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdv_status_reg i_wdv_status_reg (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .evt_end_expiry(evt_end_expiry), .evt_early_key(evt_early_key),
    .evt_bad_key(evt_bad_key), .wr_en(wr_en), .wr_priv(wr_priv),
    .wr_data(wr_data), .irq_mode(irq_mode), .rd_data(rd_data), .nmi_req(nmi_req)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d, input logic priv, input logic srst);
    wr_en = 1'b1; wr_priv = priv; wr_data = d; soft_rst = srst;
    step();
    wr_en = 1'b0; wr_priv = 1'b0; wr_data = '0; soft_rst = 1'b0;
  endtask

  task automatic pulse(input logic e_end, input logic e_early, input logic e_key);
    evt_end_expiry = e_end; evt_early_key = e_early; evt_bad_key = e_key;
    step();
    evt_end_expiry = 1'b0; evt_early_key = 1'b0; evt_bad_key = 1'b0;
  endtask

  task automatic do_por();
    por_n = 1'b0; step(); step();
    check("R1 rd_data in reset", rd_data, 32'h0);
    check("R1 nmi in reset", {31'b0, nmi_req}, 32'h0);
    por_n = 1'b1; step();
    check("R1 rd_data after reset", rd_data, 32'h0);
  endtask

  task automatic t_end_expiry();
    irq_mode = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    check("R3 end expiry sets 5,4,1", rd_data, 32'h32);
    check("R2 reserved bits zero", rd_data & 32'hFFFF_FFC1, 32'h0);
    check("R11 nmi with irq_mode", {31'b0, nmi_req}, 32'h1);
  endtask

  task automatic t_sticky();
    step(); step();
    check("R6 held without events", rd_data, 32'h32);
    soft_rst = 1'b1; step(); step(); step(); soft_rst = 1'b0; step();
    check("R6 soft reset keeps flags", rd_data, 32'h32);
    check("R6 soft reset keeps nmi", {31'b0, nmi_req}, 32'h1);
  endtask

  task automatic t_ignored_writes();
    write(32'h0, 1'b1, 1'b0);
    check("R7 zero write unchanged", rd_data, 32'h32);
    write(32'hFFFF_FFC1, 1'b1, 1'b0);
    check("R2 reserved write no effect", rd_data, 32'h32);
    write(32'h3E, 1'b0, 1'b0);
    check("R9 unprivileged write ignored", rd_data, 32'h32);
    write(32'h3E, 1'b1, 1'b1);
    check("R9 write during soft reset ignored", rd_data, 32'h32);
  endtask

  task automatic t_clear_mirror();
    write(32'h02, 1'b1, 1'b0);
    check("R7 bit1 clears shared expiry flag", rd_data, 32'h20);
    check("R11 nmi stays while bit5 set", {31'b0, nmi_req}, 32'h1);
  endtask

  task automatic t_clear_all();
    write(32'h20, 1'b1, 1'b0);
    check("R8 summary write clears all", rd_data, 32'h0);
    check("R11 nmi falls after clear", {31'b0, nmi_req}, 32'h0);
  endtask

  task automatic t_early_and_key();
    irq_mode = 1'b0;
    pulse(1'b0, 1'b1, 1'b0);
    check("R4 early key sets 5,3", rd_data, 32'h28);
    check("R11 nmi off in reset mode", {31'b0, nmi_req}, 32'h0);
    pulse(1'b0, 1'b0, 1'b1);
    check("R5 bad key adds bit2", rd_data, 32'h2C);
    write(32'h04, 1'b1, 1'b0);
    check("R7 bit2 clears only key flag", rd_data, 32'h28);
    write(32'h08, 1'b1, 1'b0);
    check("R7 bit3 clears only early flag", rd_data, 32'h20);
    write(32'h20, 1'b1, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    check("R5 bad key alone leaves bit5 clear", rd_data, 32'h04);
    irq_mode = 1'b1;
  endtask

  task automatic t_set_wins();
    evt_end_expiry = 1'b1;
    write(32'h3E, 1'b1, 1'b0);
    evt_end_expiry = 1'b0;
    check("R10 set beats clear", rd_data, 32'h32);
    check("R10 nmi raised", {31'b0, nmi_req}, 32'h1);
    write(32'h10, 1'b1, 1'b0);
    check("R7 bit4 clears expiry pair, bit5 kept", rd_data, 32'h20);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    do_por();
    t_end_expiry();
    t_sticky();
    t_ignored_writes();
    t_clear_mirror();
    t_clear_all();
    t_early_and_key();
    t_set_wins();
    do_por();
    finish_run();
  end
endmodule